// File: doc/BRIEF.md
# Precision-Time Event Stamp Capture

This block records the value of the local time counter at the moment a selected precision-time-protocol event frame crosses the receive or the transmit point. A frame is described by a start-of-frame strobe and a set of fields parsed upstream: ethertype, IP protocol, UDP source and destination ports, PTP message type and PTP version. Each direction has one programmable event class, an enable and a single stamp slot. A captured stamp stays in its slot until software collects it.

Each slot is a three-state machine. SLOT_EMPTY moves to SLOT_FULL on CAPTURE, which is a matching start-of-frame on an enabled side. SLOT_FULL moves to SLOT_HALF_READ on LOW_READ, a low-word read strobe. SLOT_HALF_READ moves to SLOT_EMPTY on HIGH_READ, a high-word read strobe. Any state moves to SLOT_EMPTY on DISABLE, when the side's enable is low. While the slot is not empty, matching frames are not stamped. They are counted instead in a saturating missed-event counter.

A separate per-packet mode serves receive buffers. For every received frame, the block presents a 16-byte prefix that holds the time of that frame's start-of-frame. The prefix is produced whether or not the frame matches the event class, and whether or not the slot is full.

Top module: `ptp_ts_capture`

## Requirements
- R1: After reset, both valid flags, both missed counters and the prefix valid flag are zero.
- R2: On a start-of-frame strobe of a matching frame, on an enabled side whose slot is empty, the slot captures the timer value present at that clock edge. The valid flag and the stamp are visible after that edge.
- R3: While a slot holds a stamp, later matching frames leave the stamp unchanged. Each such frame adds one to that side's missed counter, which saturates at 2^MISS_W-1.
- R4: A low-word read followed later by a high-word read empties the slot and clears the valid flag at the edge of the high-word read. A high-word read made before a low-word read has no effect.
- R5: A layer-4 match requires l4_filt_en=1, IP protocol 17 and UDP destination port 319. When src_port_chk=1, it also requires UDP source port 319.
- R6: A layer-2 match requires l2_filt_en=1 and ethertype 0x88F7.
- R7: The class code selects which frames match. Code 0 matches a layer-4 match with version 1 and message type 0. Code 1 matches a layer-4 match with version 1 and message type 1. Code 2 matches a layer-2 or layer-4 match with version 2 and message type 0 to 3. Code 3 matches every frame.
- R8: A side whose enable is low never sets its valid flag. Clearing an enable empties a pending slot at the next edge.
- R9: With pkt_prefix_en=1 and rx_en=1, every receive start-of-frame makes prefix_valid high for the following cycle. In that prefix, bytes 0 to 7 are zero, bytes 8 to 11 hold the timer low word and bytes 12 to 15 hold the high word, little-endian, with byte k at bits 8k+7:8k.
- R10: The receive and transmit sides capture, count and release independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_i | input | TW | Current time from the clock block |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_ethertype | input | 16 | Receive frame ethertype |
| rx_ip_proto | input | 8 | Receive IP protocol |
| rx_udp_src | input | 16 | Receive UDP source port |
| rx_udp_dst | input | 16 | Receive UDP destination port |
| rx_msg_type | input | 4 | Receive PTP message type |
| rx_version | input | 4 | Receive PTP version |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_ethertype | input | 16 | Transmit frame ethertype |
| tx_ip_proto | input | 8 | Transmit IP protocol |
| tx_udp_src | input | 16 | Transmit UDP source port |
| tx_udp_dst | input | 16 | Transmit UDP destination port |
| tx_msg_type | input | 4 | Transmit PTP message type |
| tx_version | input | 4 | Transmit PTP version |
| rx_en | input | 1 | Receive side enable |
| tx_en | input | 1 | Transmit side enable |
| rx_class | input | 2 | Receive event class code |
| tx_class | input | 2 | Transmit event class code |
| l2_filt_en | input | 1 | Layer-2 ethertype match enable |
| l4_filt_en | input | 1 | Layer-4 UDP port match enable |
| src_port_chk | input | 1 | Also require the UDP source port |
| pkt_prefix_en | input | 1 | Per-packet receive prefix mode |
| rx_rd_lo | input | 1 | Receive stamp low-word read strobe |
| rx_rd_hi | input | 1 | Receive stamp high-word read strobe |
| tx_rd_lo | input | 1 | Transmit stamp low-word read strobe |
| tx_rd_hi | input | 1 | Transmit stamp high-word read strobe |
| rx_valid | output | 1 | Receive slot holds a stamp |
| rx_stamp | output | TW | Receive stamp |
| tx_valid | output | 1 | Transmit slot holds a stamp |
| tx_stamp | output | TW | Transmit stamp |
| rx_missed | output | MISS_W | Receive missed-event count |
| tx_missed | output | MISS_W | Transmit missed-event count |
| prefix_valid | output | 1 | Prefix data valid for one cycle |
| prefix_data | output | 2*TW | 16-byte receive prefix |

## Verification
A capture, a missed-count step and a prefix all register at the rising edge that sees the start-of-frame strobe, so each is due one edge after that strobe. A release takes effect at the edge that sees the high-word read strobe, and a disable at the first edge that sees the enable low. The bench changes every input on the falling clock edge, so one rising edge separates a stimulus from its result. It reads the outputs at the next falling edge, which places every check exactly one register stage after its cause, with no race at the active edge.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;

    localparam logic [15:0] ETH_TYPE_PTP  = 16'h88F7;
    localparam logic [7:0]  IPPROTO_UDP_C = 8'd17;
    localparam logic [15:0] PTP_EVT_PORT  = 16'd319;

    typedef struct packed {
        logic [15:0] ethertype;
        logic [7:0]  ip_proto;
        logic [15:0] udp_src;
        logic [15:0] udp_dst;
        logic [3:0]  msg_type;
        logic [3:0]  version;
    } frame_desc_t;

    typedef enum logic [1:0] {
        CLS_V1_SYNC  = 2'd0,
        CLS_V1_DREQ  = 2'd1,
        CLS_V2_EVENT = 2'd2,
        CLS_ALL      = 2'd3
    } ev_class_t;

    typedef enum logic [1:0] {
        SLOT_EMPTY     = 2'd0,
        SLOT_FULL      = 2'd1,
        SLOT_HALF_READ = 2'd2
    } slot_state_t;

endpackage

// File: rtl/ptp_ts_match.sv
module ptp_ts_match
    import ptp_ts_pkg::*;
(
    input  frame_desc_t desc,
    input  ev_class_t   cls,
    input  logic        l2_en,
    input  logic        l4_en,
    input  logic        src_chk,
    output logic        hit
);
    logic l2_ok, l4_ok, v1, v2_evt;

    always_comb begin
        l2_ok  = l2_en && (desc.ethertype == ETH_TYPE_PTP);
        l4_ok  = l4_en && (desc.ip_proto == IPPROTO_UDP_C)
                 && (desc.udp_dst == PTP_EVT_PORT)
                 && (!src_chk || (desc.udp_src == PTP_EVT_PORT));
        v1     = (desc.version == 4'd1);
        v2_evt = (desc.version == 4'd2) && (desc.msg_type < 4'd4);
        unique case (cls)
            CLS_V1_SYNC:  hit = l4_ok && v1 && (desc.msg_type == 4'd0);
            CLS_V1_DREQ:  hit = l4_ok && v1 && (desc.msg_type == 4'd1);
            CLS_V2_EVENT: hit = (l2_ok || l4_ok) && v2_evt;
            CLS_ALL:      hit = 1'b1;
            default:      hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptp_ts_slot.sv
module ptp_ts_slot
    import ptp_ts_pkg::*;
#(
    parameter int TW     = 64,
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sof,
    input  logic              hit,
    input  logic [TW-1:0]     timer,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic              valid,
    output logic [TW-1:0]     stamp,
    output logic [MISS_W-1:0] missed
);
    localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

    slot_state_t state, nxt;
    logic        event_seen, capture, lost;

    always_comb begin
        event_seen = en && sof && hit;
        capture    = event_seen && (state == SLOT_EMPTY);
        lost       = event_seen && (state != SLOT_EMPTY);
        nxt        = state;
        if (!en) begin
            nxt = SLOT_EMPTY;
        end else begin
            unique case (state)
                SLOT_EMPTY:     if (capture) nxt = SLOT_FULL;
                SLOT_FULL:      if (rd_lo)   nxt = SLOT_HALF_READ;
                SLOT_HALF_READ: if (rd_hi)   nxt = SLOT_EMPTY;
                default:        nxt = SLOT_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_EMPTY;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp  <= '0;
            missed <= '0;
        end else begin
            if (capture) stamp <= timer;
            if (lost && (missed != MISS_MAX)) missed <= missed + 1'b1;
        end
    end

    assign valid = (state != SLOT_EMPTY);
endmodule

// File: rtl/ptp_ts_capture.sv
module ptp_ts_capture
    import ptp_ts_pkg::*;
#(
    parameter int TW     = 64,
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     timer_i,
    input  logic              rx_sof,
    input  logic [15:0]       rx_ethertype,
    input  logic [7:0]        rx_ip_proto,
    input  logic [15:0]       rx_udp_src,
    input  logic [15:0]       rx_udp_dst,
    input  logic [3:0]        rx_msg_type,
    input  logic [3:0]        rx_version,
    input  logic              tx_sof,
    input  logic [15:0]       tx_ethertype,
    input  logic [7:0]        tx_ip_proto,
    input  logic [15:0]       tx_udp_src,
    input  logic [15:0]       tx_udp_dst,
    input  logic [3:0]        tx_msg_type,
    input  logic [3:0]        tx_version,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic [1:0]        rx_class,
    input  logic [1:0]        tx_class,
    input  logic              l2_filt_en,
    input  logic              l4_filt_en,
    input  logic              src_port_chk,
    input  logic              pkt_prefix_en,
    input  logic              rx_rd_lo,
    input  logic              rx_rd_hi,
    input  logic              tx_rd_lo,
    input  logic              tx_rd_hi,
    output logic              rx_valid,
    output logic [TW-1:0]     rx_stamp,
    output logic              tx_valid,
    output logic [TW-1:0]     tx_stamp,
    output logic [MISS_W-1:0] rx_missed,
    output logic [MISS_W-1:0] tx_missed,
    output logic              prefix_valid,
    output logic [2*TW-1:0]   prefix_data
);
    localparam int NSIDE = 2;  // index 0 receive, 1 transmit

    frame_desc_t       s_desc   [NSIDE];
    ev_class_t         s_cls    [NSIDE];
    logic              s_en     [NSIDE];
    logic              s_sof    [NSIDE];
    logic              s_rd_lo  [NSIDE];
    logic              s_rd_hi  [NSIDE];
    logic              s_hit    [NSIDE];
    logic              s_valid  [NSIDE];
    logic [TW-1:0]     s_stamp  [NSIDE];
    logic [MISS_W-1:0] s_missed [NSIDE];

    always_comb begin
        s_desc[0] = '{ethertype: rx_ethertype, ip_proto: rx_ip_proto,
                      udp_src: rx_udp_src, udp_dst: rx_udp_dst,
                      msg_type: rx_msg_type, version: rx_version};
        s_desc[1] = '{ethertype: tx_ethertype, ip_proto: tx_ip_proto,
                      udp_src: tx_udp_src, udp_dst: tx_udp_dst,
                      msg_type: tx_msg_type, version: tx_version};
        s_cls[0]   = ev_class_t'(rx_class);
        s_cls[1]   = ev_class_t'(tx_class);
        s_en[0]    = rx_en;     s_en[1]    = tx_en;
        s_sof[0]   = rx_sof;    s_sof[1]   = tx_sof;
        s_rd_lo[0] = rx_rd_lo;  s_rd_lo[1] = tx_rd_lo;
        s_rd_hi[0] = rx_rd_hi;  s_rd_hi[1] = tx_rd_hi;
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        ptp_ts_match u_match (
            .desc    (s_desc[s]),
            .cls     (s_cls[s]),
            .l2_en   (l2_filt_en),
            .l4_en   (l4_filt_en),
            .src_chk (src_port_chk),
            .hit     (s_hit[s])
        );
        ptp_ts_slot #(.TW(TW), .MISS_W(MISS_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (s_en[s]),
            .sof    (s_sof[s]),
            .hit    (s_hit[s]),
            .timer  (timer_i),
            .rd_lo  (s_rd_lo[s]),
            .rd_hi  (s_rd_hi[s]),
            .valid  (s_valid[s]),
            .stamp  (s_stamp[s]),
            .missed (s_missed[s])
        );
    end

    assign rx_valid  = s_valid[0];
    assign tx_valid  = s_valid[1];
    assign rx_stamp  = s_stamp[0];
    assign tx_stamp  = s_stamp[1];
    assign rx_missed = s_missed[0];
    assign tx_missed = s_missed[1];

    // Prefix: two zero dwords, then timer low dword, then high dword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prefix_valid <= 1'b0;
            prefix_data  <= '0;
        end else begin
            prefix_valid <= rx_en && pkt_prefix_en && rx_sof;
            if (rx_en && pkt_prefix_en && rx_sof)
                prefix_data <= {timer_i, {TW{1'b0}}};
        end
    end
endmodule

// File: rtl/ptp_ts_capture_chk.sv
module ptp_ts_capture_chk #(
    parameter int TW     = 64,
    parameter int MISS_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_sof,
    input logic              rx_en,
    input logic              tx_en,
    input logic              rx_rd_hi,
    input logic              tx_rd_hi,
    input logic              pkt_prefix_en,
    input logic              rx_valid,
    input logic              tx_valid,
    input logic [TW-1:0]     rx_stamp,
    input logic [MISS_W-1:0] rx_missed,
    input logic              prefix_valid
);
    p_capture_on_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> ($past(rx_sof) && $past(rx_en)));

    p_stamp_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(rx_valid)) |-> (rx_stamp == $past(rx_stamp)));

    p_missed_no_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_missed >= $past(rx_missed));

    p_rx_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_valid) |-> ($past(rx_rd_hi) || !$past(rx_en)));

    p_tx_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_valid) |-> ($past(tx_rd_hi) || !$past(tx_en)));

    p_rx_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_valid);

    p_tx_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !tx_valid);

    p_prefix_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prefix_valid |-> $past(rx_sof && rx_en && pkt_prefix_en));
endmodule

bind ptp_ts_capture ptp_ts_capture_chk #(.TW(TW), .MISS_W(MISS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_en(rx_en), .tx_en(tx_en),
    .rx_rd_hi(rx_rd_hi), .tx_rd_hi(tx_rd_hi), .pkt_prefix_en(pkt_prefix_en),
    .rx_valid(rx_valid), .tx_valid(tx_valid), .rx_stamp(rx_stamp),
    .rx_missed(rx_missed), .prefix_valid(prefix_valid)
);

// File: tb/ptp_ts_capture_test.sv
module ptp_ts_capture_test;
    localparam int TW     = 64;
    localparam int MISS_W = 4;
    localparam int SAT    = (1 << MISS_W) - 1;

    typedef struct packed {
        logic [1:0]  cls;
        logic        l2, l4, sc;
        logic [15:0] eth;
        logic [7:0]  proto;
        logic [15:0] sp, dp;
        logic [3:0]  ver, msg;
        logic        hit;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 1'b0, 1'b0, 1'b0, 16'h0800, 8'd6,  16'd80,   16'd80,  4'd0, 4'd0, 1'b1}, // R7 all
        '{2'd0, 1'b0, 1'b1, 1'b0, 16'h0800, 8'd17, 16'd1000, 16'd319, 4'd1, 4'd0, 1'b1}, // R5 R7 sync
        '{2'd0, 1'b0, 1'b1, 1'b0, 16'h0800, 8'd17, 16'd1000, 16'd319, 4'd1, 4'd1, 1'b0}, // R7 wrong type
        '{2'd1, 1'b0, 1'b1, 1'b0, 16'h0800, 8'd17, 16'd1000, 16'd319, 4'd1, 4'd1, 1'b1}, // R7 delay req
        '{2'd0, 1'b0, 1'b1, 1'b0, 16'h0800, 8'd17, 16'd1000, 16'd320, 4'd1, 4'd0, 1'b0}, // R5 wrong port
        '{2'd0, 1'b0, 1'b1, 1'b0, 16'h0800, 8'd6,  16'd1000, 16'd319, 4'd1, 4'd0, 1'b0}, // R5 not UDP
        '{2'd0, 1'b0, 1'b1, 1'b1, 16'h0800, 8'd17, 16'd1000, 16'd319, 4'd1, 4'd0, 1'b0}, // R5 src check
        '{2'd0, 1'b0, 1'b1, 1'b1, 16'h0800, 8'd17, 16'd319,  16'd319, 4'd1, 4'd0, 1'b1}, // R5 src ok
        '{2'd2, 1'b1, 1'b0, 1'b0, 16'h88F7, 8'd0,  16'd0,    16'd0,   4'd2, 4'd3, 1'b1}, // R6 R7 L2
        '{2'd2, 1'b0, 1'b0, 1'b0, 16'h88F7, 8'd0,  16'd0,    16'd0,   4'd2, 4'd3, 1'b0}, // R6 L2 off
        '{2'd2, 1'b1, 1'b0, 1'b0, 16'h88F7, 8'd0,  16'd0,    16'd0,   4'd2, 4'd8, 1'b0}, // R7 general msg
        '{2'd2, 1'b0, 1'b1, 1'b0, 16'h0800, 8'd17, 16'd5,    16'd319, 4'd2, 4'd2, 1'b1}, // R7 v2 over L4
        '{2'd2, 1'b1, 1'b0, 1'b0, 16'h0800, 8'd0,  16'd0,    16'd0,   4'd2, 4'd0, 1'b0}, // R6 bad ethertype
        '{2'd0, 1'b0, 1'b0, 1'b0, 16'h0800, 8'd17, 16'd1000, 16'd319, 4'd1, 4'd0, 1'b0}  // R5 L4 off
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TW-1:0] timer_i = '0;
    logic rx_sof = 0, tx_sof = 0;
    logic [15:0] rx_ethertype = 0, rx_udp_src = 0, rx_udp_dst = 0;
    logic [15:0] tx_ethertype = 0, tx_udp_src = 0, tx_udp_dst = 0;
    logic [7:0]  rx_ip_proto = 0, tx_ip_proto = 0;
    logic [3:0]  rx_msg_type = 0, rx_version = 0, tx_msg_type = 0, tx_version = 0;
    logic rx_en = 0, tx_en = 0;
    logic [1:0] rx_class = 0, tx_class = 0;
    logic l2_filt_en = 0, l4_filt_en = 0, src_port_chk = 0, pkt_prefix_en = 0;
    logic rx_rd_lo = 0, rx_rd_hi = 0, tx_rd_lo = 0, tx_rd_hi = 0;
    logic rx_valid, tx_valid, prefix_valid;
    logic [TW-1:0] rx_stamp, tx_stamp;
    logic [MISS_W-1:0] rx_missed, tx_missed;
    logic [2*TW-1:0] prefix_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ptp_ts_capture #(.TW(TW), .MISS_W(MISS_W)) uut (.*);

    task automatic check(input logic ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rx_frame(input logic [TW-1:0] t);
        @(negedge clk);
        timer_i = t;
        rx_sof  = 1'b1;
        @(negedge clk);
        rx_sof  = 1'b0;
    endtask

    task automatic rx_release();
        @(negedge clk); rx_rd_lo = 1'b1;
        @(negedge clk); rx_rd_lo = 1'b0; rx_rd_hi = 1'b1;
        @(negedge clk); rx_rd_hi = 1'b0;
    endtask

    task automatic load_vec(input vec_t v);
        rx_class = v.cls; l2_filt_en = v.l2; l4_filt_en = v.l4; src_port_chk = v.sc;
        rx_ethertype = v.eth; rx_ip_proto = v.proto; rx_udp_src = v.sp;
        rx_udp_dst = v.dp; rx_version = v.ver; rx_msg_type = v.msg;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [TW-1:0] t0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!rx_valid && !tx_valid, "R1 valid", {rx_valid, tx_valid}, 0);
        check(rx_missed == 0 && tx_missed == 0, "R1 missed", {rx_missed, tx_missed}, 0);
        check(!prefix_valid, "R1 prefix", prefix_valid, 0);
        rst_n = 1'b1;
        rx_en = 1'b1; tx_en = 1'b1;

        // R5 R6 R7 R2: matching table
        for (int i = 0; i < NV; i++) begin
            t0 = {32'hA500_0000 + 32'(i), 32'h0000_1000 * 32'(i) + 32'd7};
            load_vec(VECS[i]);
            rx_frame(t0);
            check(rx_valid == VECS[i].hit, $sformatf("R5/R6/R7 vector %0d", i),
                  rx_valid, VECS[i].hit);
            if (VECS[i].hit)
                check(rx_stamp == t0, $sformatf("R2 stamp vector %0d", i), rx_stamp, t0);
            rx_release();
            check(!rx_valid, "R4 released", rx_valid, 0);
        end
        check(rx_missed == 0, "R3 no miss yet", rx_missed, 0);

        // R3 hold and missed count
        load_vec(VECS[0]);
        rx_frame(64'h1234_5678_9ABC_DEF0);
        rx_frame(64'h1111_2222_3333_4444);
        check(rx_stamp == 64'h1234_5678_9ABC_DEF0, "R3 stamp held",
              rx_stamp, 64'h1234_5678_9ABC_DEF0);
        check(rx_missed == 1, "R3 miss one", rx_missed, 1);
        rx_frame(64'h5);
        check(rx_missed == 2, "R3 miss two", rx_missed, 2);
        for (int k = 0; k < 20; k++) rx_frame(64'(k));
        check(rx_missed == SAT, "R3 saturate", rx_missed, SAT);
        check(rx_stamp == 64'h1234_5678_9ABC_DEF0, "R3 still held",
              rx_stamp, 64'h1234_5678_9ABC_DEF0);

        // R4 read ordering
        @(negedge clk); rx_rd_hi = 1'b1;
        @(negedge clk); rx_rd_hi = 1'b0;
        check(rx_valid, "R4 high first ignored", rx_valid, 1);
        rx_rd_lo = 1'b1;
        @(negedge clk); rx_rd_lo = 1'b0;
        check(rx_valid, "R4 after low only", rx_valid, 1);
        rx_rd_hi = 1'b1;
        @(negedge clk); rx_rd_hi = 1'b0;
        check(!rx_valid, "R4 after high", rx_valid, 0);

        // R8 enables
        rx_en = 1'b0;
        rx_frame(64'h77);
        check(!rx_valid, "R8 disabled no capture", rx_valid, 0);
        rx_en = 1'b1;
        rx_frame(64'h88);
        check(rx_valid && rx_stamp == 64'h88, "R8 re-enabled capture", rx_stamp, 64'h88);
        rx_en = 1'b0;
        @(negedge clk);
        check(!rx_valid, "R8 clear on disable", rx_valid, 0);
        rx_en = 1'b1;
        @(negedge clk);
        check(!rx_valid, "R8 stays empty", rx_valid, 0);

        // R10 independent transmit side
        tx_class = 2'd3;
        @(negedge clk); timer_i = 64'hDEAD_BEEF_0000_0042; tx_sof = 1'b1;
        @(negedge clk); tx_sof = 1'b0;
        check(tx_valid && tx_stamp == 64'hDEAD_BEEF_0000_0042, "R10 tx capture",
              tx_stamp, 64'hDEAD_BEEF_0000_0042);
        check(!rx_valid && tx_missed == 0, "R10 rx untouched", rx_valid, 0);
        tx_rd_lo = 1'b1;
        @(negedge clk); tx_rd_lo = 1'b0; tx_rd_hi = 1'b1;
        @(negedge clk); tx_rd_hi = 1'b0;
        check(!tx_valid, "R10 tx release", tx_valid, 0);

        // R9 per-packet prefix on a non-matching frame
        pkt_prefix_en = 1'b1;
        load_vec(VECS[13]);
        rx_frame(64'hCAFE_F00D_0BAD_BEEF);
        check(prefix_valid, "R9 prefix valid", prefix_valid, 1);
        check(prefix_data == {64'hCAFE_F00D_0BAD_BEEF, 64'h0}, "R9 prefix data",
              prefix_data, {64'hCAFE_F00D_0BAD_BEEF, 64'h0});
        check(prefix_data[95:64] == 32'h0BAD_BEEF, "R9 dword2 low word",
              prefix_data[95:64], 32'h0BAD_BEEF);
        check(!rx_valid, "R9 slot untouched", rx_valid, 0);
        @(negedge clk);
        check(!prefix_valid, "R9 prefix one cycle", prefix_valid, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule